// File: doc/BRIEF.md
# Opportunistic Store Verify Scheduler

This block sits beside a data cache that has two fully pipelined read ports. Every cycle, ready loads and stores claim the ports they need. Stores waiting to be verified sit in a small queue, and any port left idle goes to the oldest of them. A verify reads the value currently held at the store's address. One cycle later the cache returns a hit flag and the data. The block compares that data with the store's own data and records whether the store would leave memory unchanged.

When the reorder-buffer head commits a store, the block answers in the same cycle: either squash the store (no cache write) or perform the write. A store gets no silence decision if its verify has not completed, if its verify missed, or if its data differed. Such a store is written normally. A verify result that comes back after its store has committed is thrown away. Three running counters report how many verifies were issued, how many silent stores were found, and how many stores committed with no completed verify.

Stores are allocated and committed in program order, identified by a slot tag that the surrounding core recycles modulo the slot count. The cache arrays and the reorder buffer are outside the block.

Top module: `stv_sched`

## Requirements
- R1: A high `op_req[p]` means a ready load or store owns port p in that cycle, and the block never drives `vfy_issue[p]` in that cycle.
- R2: In each cycle the number of verifies issued equals the smaller of two counts: the number of ports with `op_req` low, and the number of queued stores that are not committing in that cycle. The lowest-numbered idle port carries the oldest of those stores.
- R3: Verifies issue in store allocation order, including when slot tags wrap around. `vfy_addr[p]` carries the address given at allocation.
- R4: Suppose a verify response arrives in the cycle after issue with `rsp_hit` high and `rsp_data` equal to the store data. A commit of that store in any later cycle then gives `cmt_squash`=1 and `cmt_write`=0.
- R5: A verify that hits with data different from the store data leaves the store non-silent, so its commit gives `cmt_write`=1 and `cmt_squash`=0.
- R6: A verify response with `rsp_hit` low leaves the store non-silent, so its commit gives `cmt_write`=1.
- R7: A store committed before or in the same cycle as its verify response is written (`cmt_write`=1) and adds one to `cnt_unverified`. Its late response changes neither `cnt_silent` nor any later decision.
- R8: A store committed while still queued is removed from the queue and never issued. In that same cycle, the next queued store may take an idle port.
- R9: `cnt_issued` grows by the number of verifies issued, `cnt_silent` by the number of accepted responses that find a silent store, and `cnt_unverified` by one for each commit with no completed verify.
- R10: While reset is asserted and after it is released, no verify issues until a store is allocated, and all three counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | NPORT | Port p is taken by a ready load or store this cycle |
| vfy_issue | output | NPORT | Verify read issued on port p |
| vfy_addr | output | NPORT x ADDR_W | Address of the verify read on port p |
| rsp_hit | input | NPORT | Cache hit for the verify issued on port p one cycle earlier |
| rsp_data | input | NPORT x DATA_W | Old data for the verify issued on port p one cycle earlier |
| st_alloc | input | 1 | A store enters the verify queue |
| st_tag | input | TAG_W | Slot tag of the allocated store |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| cmt_valid | input | 1 | Reorder-buffer head commits a store |
| cmt_tag | input | TAG_W | Slot tag of the committing store |
| cmt_squash | output | 1 | Committing store is silent; no cache write |
| cmt_write | output | 1 | Committing store must write the cache |
| cnt_issued | output | CNT_W | Verifies issued |
| cnt_silent | output | CNT_W | Silent stores found |
| cnt_unverified | output | CNT_W | Stores committed with no completed verify |

## Verification
The main function is driven with three port patterns: both ports busy, which must hold every verify back; one port free, which checks that the free port is chosen; and both ports free, which checks that two queued stores issue in age order in one cycle. Verify outcomes are exercised with a matching hit, a differing hit and a miss, which separates the silent decision from the two non-silent paths. Three timing cases test the commit race: a commit landing in the same cycle as the response, a commit of a still-queued store while a port is free, and a slot tag reused after the queue pointers wrap. Each case shows whether late results are discarded and whether queue order survives.

// File: rtl/stv_pkg.sv
package stv_pkg;

  // Commit decision: a store is squashed only when its verify finished and matched.
  function automatic logic commit_squash(input logic verified, input logic matched);
    return verified & matched;
  endfunction

  // Silence test applied to one verify response.
  function automatic logic resp_silent(input logic hit, input logic [63:0] old_v,
                                       input logic [63:0] new_v);
    return hit && (old_v == new_v);
  endfunction

endpackage

// File: rtl/stv_vq.sv
module stv_vq #(
  parameter int NTAG  = 8,
  parameter int TAG_W = 3,
  parameter int QC_W  = 4,
  parameter int POP_W = 2,
  parameter int PK    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [TAG_W-1:0]          push_tag,
  input  logic [POP_W-1:0]          pop_n,
  output logic [QC_W-1:0]           count,
  output logic [PK-1:0][TAG_W-1:0]  peek
);

  logic [NTAG-1:0][TAG_W-1:0] mem;
  logic [TAG_W-1:0]           head, tail;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      head  <= head + TAG_W'(pop_n);
      count <= count + QC_W'(push) - QC_W'(pop_n);
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_tag;
  end

  for (genvar k = 0; k < PK; k++) begin : g_peek
    assign peek[k] = mem[head + TAG_W'(k)];
  end

endmodule

// File: rtl/stv_palloc.sv
module stv_palloc #(
  parameter int NPORT = 2,
  parameter int QC_W  = 4,
  parameter int SEL_W = 2
) (
  input  logic [NPORT-1:0]             op_req,
  input  logic [QC_W-1:0]              avail,
  output logic [NPORT-1:0]             issue,
  output logic [NPORT-1:0][SEL_W-1:0]  sel,
  output logic [SEL_W-1:0]             n_iss
);

  always_comb begin
    logic [SEL_W-1:0] rank;
    rank  = '0;
    issue = '0;
    sel   = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (!op_req[p] && (int'(rank) < int'(avail))) begin
        issue[p] = 1'b1;
        sel[p]   = rank;
        rank     = rank + 1'b1;
      end
    end
    n_iss = rank;
  end

endmodule

// File: rtl/stv_tbl.sv
module stv_tbl #(
  parameter int NPORT  = 2,
  parameter int NTAG   = 8,
  parameter int TAG_W  = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             alloc,
  input  logic [TAG_W-1:0]                 alloc_tag,
  input  logic [ADDR_W-1:0]                alloc_addr,
  input  logic [DATA_W-1:0]                alloc_data,
  input  logic [NPORT-1:0]                 iss,
  input  logic [NPORT-1:0][TAG_W-1:0]      iss_tag,
  input  logic [NPORT-1:0]                 rsp_v,
  input  logic [NPORT-1:0][TAG_W-1:0]      rsp_tag,
  input  logic [NPORT-1:0]                 rsp_hit,
  input  logic [NPORT-1:0][DATA_W-1:0]     rsp_data,
  input  logic                             cmt,
  input  logic [TAG_W-1:0]                 cmt_tag,
  output logic [NTAG-1:0][ADDR_W-1:0]      ent_addr,
  output logic [NTAG-1:0]                  done,
  output logic [NTAG-1:0]                  sil,
  output logic [NPORT-1:0]                 rsp_ok,
  output logic [NPORT-1:0]                 rsp_sil
);

  logic [NTAG-1:0][DATA_W-1:0] ent_data;
  logic [NTAG-1:0]             infl;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rsp_ok[p]  = rsp_v[p] && infl[rsp_tag[p]] && !(cmt && (cmt_tag == rsp_tag[p]));
      rsp_sil[p] = stv_pkg::resp_silent(rsp_hit[p], 64'(rsp_data[p]),
                                        64'(ent_data[rsp_tag[p]]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done <= '0;
      sil  <= '0;
      infl <= '0;
    end else begin
      for (int t = 0; t < NTAG; t++) begin
        if (alloc && (alloc_tag == TAG_W'(t))) begin
          done[t] <= 1'b0;
          sil[t]  <= 1'b0;
          infl[t] <= 1'b0;
        end else begin
          if (cmt && (cmt_tag == TAG_W'(t))) infl[t] <= 1'b0;
          for (int p = 0; p < NPORT; p++) begin
            if (iss[p] && (iss_tag[p] == TAG_W'(t))) infl[t] <= 1'b1;
            if (rsp_ok[p] && (rsp_tag[p] == TAG_W'(t))) begin
              done[t] <= 1'b1;
              sil[t]  <= rsp_sil[p];
              infl[t] <= 1'b0;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc) begin
      ent_addr[alloc_tag] <= alloc_addr;
      ent_data[alloc_tag] <= alloc_data;
    end
  end

endmodule

// File: rtl/stv_sched.sv
module stv_sched #(
  parameter int NPORT  = 2,
  parameter int NTAG   = 8,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  localparam int TAG_W = $clog2(NTAG)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NPORT-1:0]              op_req,
  output logic [NPORT-1:0]              vfy_issue,
  output logic [NPORT-1:0][ADDR_W-1:0]  vfy_addr,
  input  logic [NPORT-1:0]              rsp_hit,
  input  logic [NPORT-1:0][DATA_W-1:0]  rsp_data,
  input  logic                          st_alloc,
  input  logic [TAG_W-1:0]              st_tag,
  input  logic [ADDR_W-1:0]             st_addr,
  input  logic [DATA_W-1:0]             st_data,
  input  logic                          cmt_valid,
  input  logic [TAG_W-1:0]              cmt_tag,
  output logic                          cmt_squash,
  output logic                          cmt_write,
  output logic [CNT_W-1:0]              cnt_issued,
  output logic [CNT_W-1:0]              cnt_silent,
  output logic [CNT_W-1:0]              cnt_unverified
);

  localparam int QC_W  = $clog2(NTAG + 1);
  localparam int SEL_W = $clog2(NPORT + 1);
  localparam int POP_W = $clog2(NPORT + 2);
  localparam int PK    = 1 << SEL_W;

  logic [QC_W-1:0]                q_count;
  logic [PK-1:0][TAG_W-1:0]       q_peek;
  logic [POP_W-1:0]               pop_n;
  logic                           head_commit;
  logic [QC_W-1:0]                avail;
  logic [NPORT-1:0][SEL_W-1:0]    sel;
  logic [SEL_W-1:0]               n_iss;
  logic [NPORT-1:0][TAG_W-1:0]    vfy_tag;
  logic [NPORT-1:0]               ifl_v;
  logic [NPORT-1:0][TAG_W-1:0]    ifl_tag;
  logic [NTAG-1:0][ADDR_W-1:0]    ent_addr;
  logic [NTAG-1:0]                done, sil;
  logic [NPORT-1:0]               rsp_ok, rsp_sil;

  // A committing store that was never issued is necessarily the queue head.
  assign head_commit = cmt_valid && (q_count != '0) && (q_peek[0] == cmt_tag);
  assign avail       = q_count - QC_W'(head_commit);
  assign pop_n       = POP_W'(head_commit) + POP_W'(n_iss);

  stv_vq #(.NTAG(NTAG), .TAG_W(TAG_W), .QC_W(QC_W), .POP_W(POP_W), .PK(PK)) u_vq (
    .clk(clk), .rst_n(rst_n), .push(st_alloc), .push_tag(st_tag),
    .pop_n(pop_n), .count(q_count), .peek(q_peek));

  stv_palloc #(.NPORT(NPORT), .QC_W(QC_W), .SEL_W(SEL_W)) u_pa (
    .op_req(op_req), .avail(avail), .issue(vfy_issue), .sel(sel), .n_iss(n_iss));

  always_comb begin
    logic [SEL_W-1:0] idx;
    for (int p = 0; p < NPORT; p++) begin
      idx         = SEL_W'(head_commit) + sel[p];
      vfy_tag[p]  = q_peek[idx];
      vfy_addr[p] = vfy_issue[p] ? ent_addr[vfy_tag[p]] : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifl_v   <= '0;
      ifl_tag <= '0;
    end else begin
      ifl_v   <= vfy_issue;
      ifl_tag <= vfy_tag;
    end
  end

  stv_tbl #(.NPORT(NPORT), .NTAG(NTAG), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .alloc(st_alloc), .alloc_tag(st_tag), .alloc_addr(st_addr), .alloc_data(st_data),
    .iss(vfy_issue), .iss_tag(vfy_tag),
    .rsp_v(ifl_v), .rsp_tag(ifl_tag), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .cmt(cmt_valid), .cmt_tag(cmt_tag),
    .ent_addr(ent_addr), .done(done), .sil(sil), .rsp_ok(rsp_ok), .rsp_sil(rsp_sil));

  assign cmt_squash = cmt_valid && stv_pkg::commit_squash(done[cmt_tag], sil[cmt_tag]);
  assign cmt_write  = cmt_valid && !cmt_squash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_issued     <= '0;
      cnt_silent     <= '0;
      cnt_unverified <= '0;
    end else begin
      cnt_issued     <= cnt_issued + CNT_W'(n_iss);
      cnt_silent     <= cnt_silent + CNT_W'($countones(rsp_ok & rsp_sil));
      cnt_unverified <= cnt_unverified + CNT_W'(cmt_valid && !done[cmt_tag]);
    end
  end

endmodule

// File: rtl/stv_sched_chk.sv
module stv_sched_chk #(
  parameter int NPORT = 2,
  parameter int TAG_W = 3,
  parameter int QC_W  = 4,
  parameter int CNT_W = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NPORT-1:0]           op_req,
  input logic [NPORT-1:0]           vfy_issue,
  input logic [NPORT-1:0][TAG_W-1:0] vfy_tag,
  input logic [QC_W-1:0]            avail,
  input logic                       cmt_valid,
  input logic [TAG_W-1:0]           cmt_tag,
  input logic                       cmt_squash,
  input logic                       cmt_write,
  input logic [CNT_W-1:0]           cnt_issued
);

  a_r1_ops_first: assert property (@(posedge clk) disable iff (!rst_n)
    (vfy_issue & op_req) == '0);

  a_r2_spare_used: assert property (@(posedge clk) disable iff (!rst_n)
    ((avail != '0) && (op_req != '1)) |-> (vfy_issue != '0));

  a_r4_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> ($countones({cmt_squash, cmt_write}) == 1));

  a_r4_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmt_valid |-> !(cmt_squash || cmt_write));

  a_r9_issue_tally: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_issued == $past(cnt_issued) + CNT_W'($countones($past(vfy_issue)))));

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    a_r8_no_commit_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_valid && vfy_issue[p]) |-> (vfy_tag[p] != cmt_tag));
  end

endmodule

bind stv_sched stv_sched_chk #(.NPORT(NPORT), .TAG_W(TAG_W), .QC_W(QC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_req(op_req), .vfy_issue(vfy_issue), .vfy_tag(vfy_tag),
  .avail(avail), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_squash(cmt_squash),
  .cmt_write(cmt_write), .cnt_issued(cnt_issued));

// File: tb/sim_stv_sched.sv
module sim_stv_sched;

  localparam int NP = 2, NT = 8, AW = 16, DW = 32, CW = 16, TW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] op_req = '0;
  logic [NP-1:0] vfy_issue;
  logic [NP-1:0][AW-1:0] vfy_addr;
  logic [NP-1:0] rsp_hit = '0;
  logic [NP-1:0][DW-1:0] rsp_data = '0;
  logic st_alloc = 1'b0;
  logic [TW-1:0] st_tag = '0;
  logic [AW-1:0] st_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic cmt_valid = 1'b0;
  logic [TW-1:0] cmt_tag = '0;
  logic cmt_squash, cmt_write;
  logic [CW-1:0] cnt_issued, cnt_silent, cnt_unverified;

  always #10 clk = ~clk;

  stv_sched #(.NPORT(NP), .NTAG(NT), .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .op_req(op_req), .vfy_issue(vfy_issue), .vfy_addr(vfy_addr),
    .rsp_hit(rsp_hit), .rsp_data(rsp_data), .st_alloc(st_alloc), .st_tag(st_tag),
    .st_addr(st_addr), .st_data(st_data), .cmt_valid(cmt_valid), .cmt_tag(cmt_tag),
    .cmt_squash(cmt_squash), .cmt_write(cmt_write), .cnt_issued(cnt_issued),
    .cnt_silent(cnt_silent), .cnt_unverified(cnt_unverified));

  typedef struct { int port; logic [AW-1:0] addr; string req; } iss_t;
  typedef struct { logic sq; string req; } cm_t;
  iss_t exp_iss[$];
  cm_t  exp_cm[$];

  int checks = 0, errors = 0;
  logic [DW-1:0] cmem [16];
  logic          cpres [16];

  logic [NP-1:0] s_op = '0;
  logic s_alloc = 0, s_cmt = 0;
  logic [TW-1:0] s_tag = '0, s_ctag = '0;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_data = '0;
  logic [NP-1:0] prev_iss = '0;
  logic [NP-1:0][AW-1:0] prev_addr = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then act as the monitor.
  task automatic tick();
    @(negedge clk);
    op_req = s_op; st_alloc = s_alloc; st_tag = s_tag; st_addr = s_addr; st_data = s_data;
    cmt_valid = s_cmt; cmt_tag = s_ctag;
    for (int p = 0; p < NP; p++) begin
      rsp_hit[p]  = prev_iss[p] ? cpres[prev_addr[p][3:0]] : 1'b0;
      rsp_data[p] = cmem[prev_addr[p][3:0]];
    end
    #1;
    for (int p = 0; p < NP; p++) begin
      if (vfy_issue[p]) begin
        if (exp_iss.size() == 0) begin
          chk(0, "R1", "unexpected verify on port", p, -1);
        end else begin
          iss_t e = exp_iss.pop_front();
          chk(e.port == p, e.req, "verify port", p, e.port);
          chk(vfy_addr[p] == e.addr, e.req, "verify address", vfy_addr[p], e.addr);
        end
      end
    end
    prev_iss = vfy_issue; prev_addr = vfy_addr;
    if (cmt_valid) begin
      if (exp_cm.size() == 0) begin
        chk(0, "R4", "unexpected commit", 1, 0);
      end else begin
        cm_t c = exp_cm.pop_front();
        chk(cmt_squash == c.sq, c.req, "cmt_squash", cmt_squash, c.sq);
        chk(cmt_write == !c.sq, c.req, "cmt_write", cmt_write, !c.sq);
      end
    end
    s_alloc = 0; s_cmt = 0;
  endtask

  task automatic alloc(input int tag, input int addr, input int data);
    s_alloc = 1; s_tag = TW'(tag); s_addr = AW'(addr); s_data = DW'(data);
    tick();
  endtask

  task automatic commit(input int tag, input logic sq, input string req);
    cm_t c;
    c.sq = sq; c.req = req;
    exp_cm.push_back(c);
    s_cmt = 1; s_ctag = TW'(tag);
  endtask

  task automatic expect_iss(input int port, input int addr, input string req);
    iss_t e;
    e.port = port; e.addr = AW'(addr); e.req = req;
    exp_iss.push_back(e);
  endtask

  task automatic counters(input int iss, input int sil, input int unv, input string req);
    chk(cnt_issued == CW'(iss), req, "cnt_issued", cnt_issued, iss);
    chk(cnt_silent == CW'(sil), req, "cnt_silent", cnt_silent, sil);
    chk(cnt_unverified == CW'(unv), req, "cnt_unverified", cnt_unverified, unv);
    chk(exp_iss.size() == 0, req, "expected verifies left", exp_iss.size(), 0);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      cmem[i] = DW'(32'h100 + i);
      cpres[i] = (i != 3);
    end
    // R10: reset state
    repeat (3) @(negedge clk);
    #1;
    chk(vfy_issue == '0, "R10", "vfy_issue in reset", vfy_issue, 0);
    @(negedge clk); rst_n = 1'b1;
    s_op = 2'b00;
    tick();
    chk(vfy_issue == '0, "R10", "vfy_issue empty queue", vfy_issue, 0);
    counters(0, 0, 0, "R10");

    // S1: R1 port priority, R4 silent squash
    s_op = 2'b11;
    alloc(0, 1, 32'h101);
    tick();
    chk(vfy_issue == '0, "R1", "verify with both ports busy", vfy_issue, 0);
    s_op = 2'b01; expect_iss(1, 1, "R1");
    tick();
    s_op = 2'b11;
    tick();
    commit(0, 1'b1, "R4");
    tick();
    counters(1, 1, 0, "R9");

    // S2: two verifies in one cycle, oldest first; mismatch, miss, match
    alloc(1, 2, 32'hBAD);
    alloc(2, 3, 32'h103);
    alloc(3, 4, 32'h104);
    s_op = 2'b00;
    expect_iss(0, 2, "R2"); expect_iss(1, 3, "R3");
    tick();
    expect_iss(0, 4, "R2");
    tick();
    s_op = 2'b11;
    tick();
    commit(1, 1'b0, "R5"); tick();
    commit(2, 1'b0, "R6"); tick();
    commit(3, 1'b1, "R4"); tick();
    counters(4, 2, 0, "R9");

    // S3: commit in the same cycle as the response
    alloc(4, 1, 32'h101);
    s_op = 2'b00; expect_iss(0, 1, "R2");
    tick();
    s_op = 2'b11;
    commit(4, 1'b0, "R7");
    tick();
    tick();
    counters(5, 2, 1, "R7");

    // S4: commit of a still-queued store while port 0 is free
    alloc(5, 5, 32'h105);
    alloc(6, 6, 32'h106);
    s_op = 2'b10;
    commit(5, 1'b0, "R8");
    expect_iss(0, 6, "R8");
    tick();
    s_op = 2'b11;
    tick();
    commit(6, 1'b1, "R8");
    tick();
    counters(6, 3, 2, "R8");

    // S5: tag reuse after wrap
    alloc(7, 7, 32'h999);
    alloc(0, 8, 32'h108);
    s_op = 2'b00;
    expect_iss(0, 7, "R3"); expect_iss(1, 8, "R3");
    tick();
    s_op = 2'b11;
    tick();
    commit(7, 1'b0, "R5"); tick();
    commit(0, 1'b1, "R3"); tick();
    counters(8, 4, 2, "R9");
    chk(exp_cm.size() == 0, "R4", "expected commits left", exp_cm.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule